// File: doc/BRIEF.md
# ADC Conversion Chain Sequencer

This block schedules conversions for a multi-channel analog-to-digital converter. Software programs two channel masks, one for a normal chain and one for an injected chain. A start command then walks the enabled channels of that chain from the lowest channel number to the highest. An external trigger unit can also ask for a single channel to be converted at once. For each channel the sequencer drives a channel select, a sample strobe held for a programmed number of cycles, and then a convert strobe held for a programmed number of cycles. A small converter stub captures the selected input while the sample strobe is high. When the convert phase ends, the sequencer stores that value as the channel's result and sets the channel's end-of-conversion flag.

The three request sources are ranked trigger, then injected, then normal. When a higher-ranked request arrives, the channel in progress is abandoned and the sequencer returns to idle. The abandoned channel keeps its place in its chain's list of remaining channels, so it is converted again once the higher-ranked work is done. Software can abandon only the current channel, or end the whole active chain. Each chain type has its own end-of-chain flag, cleared by writing 1. The normal chain runs either once or repeats until it is ended.

Top module: `adc_chain_seq`

## Requirements
- R1: After reset, sample_stb and conv_stb are low, the status register (address 4) reads 0 and the end-of-conversion register (address 5) reads 0.
- R2: Bit c of the normal mask (address 1) enables channel c. A normal start (control address 0, bit 1) converts the enabled channels in ascending order. Each channel shows sample_stb for S cycles and then conv_stb for C cycles with ch_sel steady, and the next channel's sample phase follows at once.
- R3: The timing register (address 3) holds S in bits 3:0 and C in bits 7:4. Any value below 2 acts as 2.
- R4: Each completed conversion sets bit c of address 5 and loads address 8+c with the input slice ain[8c+7:8c] that was present while sampling. Writing 1 to a bit of address 5 clears it. A channel that was abandoned and not converted again leaves its bit clear.
- R5: Status bit 0 reads 1 while a normal chain has channels left. In one-shot mode it returns to 0 when the chain ends, and status bit 2 (normal end-of-chain) is set at that point. Status bits 3:2 clear when 1 is written to them.
- R6: With scan mode on (control bit 0), the normal chain restarts at its lowest channel after its last channel and status bit 0 stays 1. An end-chain command stops the repetition.
- R7: A normal start issued while a normal chain is running is held. After the current chain ends, a second full chain runs in ascending order.
- R8: An injected start (control bit 2, injected mask at address 2) interrupts a normal chain. The normal channel in progress is abandoned, all injected channels are converted, and then that normal channel and the rest of the normal chain follow. Status bit 3 (injected end-of-chain) is set.
- R9: An abandon-channel command (control bit 4) ends only the current channel. The chain continues with its next channel, and any interrupted normal chain still finishes every remaining channel.
- R10: An end-chain command (control bit 5) stops the active chain at once and sets that chain's end-of-chain flag. It acts only once, so a later start runs a full chain.
- R11: With trigger enable (control bit 3) set, a trig_req pulse converts channel trig_ch ahead of any chain. A running chain channel is abandoned and then converted again. A pulse in any cycle of a running chain is converted exactly once.
- R12: Abandon-channel and end-chain commands issued while idle have no effect, and a later trigger is still converted. A trig_req with trigger enable clear is ignored.
- R13: A channel interrupted during its convert phase is converted again in full and its result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Register read data, combinational |
| trig_req | input | 1 | Single-channel request from the trigger unit |
| trig_ch | input | CHW | Channel for the trigger request |
| ain | input | NCH*DW | Per-channel input values for the converter stub |
| ch_sel | output | CHW | Channel being sampled or converted |
| sample_stb | output | 1 | High during the sample phase |
| conv_stb | output | 1 | High during the convert phase |

## Verification
Two things can fall in the same cycle: a trigger arriving and the sequencer moving between states (idle to sample, sample to convert, convert to the next sample, convert to idle). The bench sweeps the cycle in which a trigger is issued across every cycle of a two-channel normal chain and beyond its end. For each offset it judges the logged strobe sequence: the trigger channel must be converted exactly once and every normal channel must still complete. In the same way, a restart request and an injected start are placed on the last channel of a chain, and the result must keep the ascending order with the interrupted channel restored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_WAIT} seq_st_e;
  typedef enum logic [1:0] {K_NORM, K_INJ, K_TRIG} src_e;
endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*DW-1:0] ain_i,
  input  logic [CHW-1:0]    ch_i,
  input  logic              sample_i,
  output logic [DW-1:0]     data_o
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (sample_i) hold_q <= ain_i[ch_i*DW +: DW];
  end

  assign data_o = hold_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int TW  = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scan_i,
  input  logic [NCH-1:0] nmask_i,
  input  logic [NCH-1:0] jmask_i,
  input  logic [TW-1:0]  samp_i,
  input  logic [TW-1:0]  conv_i,
  input  logic           nstart_i,
  input  logic           jstart_i,
  input  logic           abort_ch_i,
  input  logic           abort_chain_i,
  input  logic           trig_en_i,
  input  logic           trig_req_i,
  input  logic [CHW-1:0] trig_ch_i,
  output logic [CHW-1:0] ch_o,
  output logic           sample_o,
  output logic           conv_o,
  output logic           done_o,
  output logic           n_eoc_o,
  output logic           j_eoc_o,
  output logic           nbusy_o,
  output logic           jbusy_o
);
  localparam logic [TW-1:0] MINCYC = TW'(2);

  seq_st_e        st_q, st_d;
  src_e           src_q, src_d;
  logic [CHW-1:0] cur_q, cur_d, tch_q, tch_d;
  logic [TW-1:0]  cnt_q, cnt_d, samp_eff, conv_eff;
  logic [NCH-1:0] nrem_q, nrem_d, jrem_q, jrem_d, cur_bit;
  logic           npend_q, npend_d, tpend_q, tpend_d;
  logic           dispatch, preempt;

  function automatic logic [CHW-1:0] lowest(input logic [NCH-1:0] m);
    lowest = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) lowest = CHW'(i);
  endfunction

  assign samp_eff = (samp_i < MINCYC) ? MINCYC : samp_i;
  assign conv_eff = (conv_i < MINCYC) ? MINCYC : conv_i;
  assign cur_bit  = NCH'(1) << cur_q;
  assign preempt  = ((src_q == K_NORM) && (tpend_q || (|jrem_q))) ||
                    ((src_q == K_INJ) && tpend_q);

  always_comb begin
    st_d = st_q;   src_d = src_q;   cur_d = cur_q;   cnt_d = cnt_q;
    nrem_d = nrem_q; jrem_d = jrem_q; npend_d = npend_q;
    tpend_d = tpend_q; tch_d = tch_q;
    done_o = 1'b0; dispatch = 1'b0;
    if (st_q == ST_IDLE) begin
      dispatch = 1'b1;
    end else if (abort_chain_i) begin
      unique case (src_q)
        K_NORM:  nrem_d = '0;
        K_INJ:   jrem_d = '0;
        default: tpend_d = 1'b0;
      endcase
      st_d = ST_IDLE;
    end else if (abort_ch_i || (st_q == ST_WAIT && cnt_q == '0)) begin
      done_o = !abort_ch_i;
      unique case (src_q)
        K_NORM:  nrem_d = nrem_q & ~cur_bit;
        K_INJ:   jrem_d = jrem_q & ~cur_bit;
        default: tpend_d = 1'b0;
      endcase
      st_d     = ST_IDLE;
      dispatch = !abort_ch_i;
    end else if (preempt) begin
      st_d = ST_IDLE;
    end else if (st_q == ST_SAMPLE && cnt_q == '0) begin
      st_d  = ST_WAIT;
      cnt_d = conv_eff - TW'(1);
    end else begin
      cnt_d = cnt_q - TW'(1);
    end
    // start requests
    if (nstart_i) begin
      if (|nrem_q) npend_d = 1'b1;
      else         nrem_d  = nmask_i;
    end
    if (jstart_i && !(|jrem_q)) jrem_d = jmask_i;
    // end-of-chain handling, scan repeat and held restart
    n_eoc_o = (|nrem_q) && !(|nrem_d);
    j_eoc_o = (|jrem_q) && !(|jrem_d);
    if (n_eoc_o) begin
      if (!(abort_chain_i && src_q == K_NORM) && (scan_i || npend_d))
        nrem_d = nmask_i;
      npend_d = 1'b0;
    end
    // trigger capture
    if (!trig_en_i) begin
      tpend_d = 1'b0;
    end else if (trig_req_i && !tpend_d) begin
      tpend_d = 1'b1;
      tch_d   = trig_ch_i;
    end
    // choose the next channel by rank
    if (dispatch) begin
      st_d  = ST_SAMPLE;
      cnt_d = samp_eff - TW'(1);
      if (tpend_d) begin
        src_d = K_TRIG; cur_d = tch_d;
      end else if (|jrem_d) begin
        src_d = K_INJ;  cur_d = lowest(jrem_d);
      end else if (|nrem_d) begin
        src_d = K_NORM; cur_d = lowest(nrem_d);
      end else begin
        st_d  = ST_IDLE;
        cnt_d = cnt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; src_q <= K_NORM; cur_q <= '0; cnt_q <= '0;
      nrem_q <= '0; jrem_q <= '0; npend_q <= 1'b0; tpend_q <= 1'b0; tch_q <= '0;
    end else begin
      st_q <= st_d; src_q <= src_d; cur_q <= cur_d; cnt_q <= cnt_d;
      nrem_q <= nrem_d; jrem_q <= jrem_d; npend_q <= npend_d;
      tpend_q <= tpend_d; tch_q <= tch_d;
    end
  end

  assign ch_o     = cur_q;
  assign sample_o = (st_q == ST_SAMPLE);
  assign conv_o   = (st_q == ST_WAIT);
  assign nbusy_o  = |nrem_q;
  assign jbusy_o  = |jrem_q;
endmodule

// File: rtl/adc_chain_seq.sv
module adc_chain_seq #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int TW  = 4,
  parameter int AW  = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              trig_req,
  input  logic [CHW-1:0]    trig_ch,
  input  logic [NCH*DW-1:0] ain,
  output logic [CHW-1:0]    ch_sel,
  output logic              sample_stb,
  output logic              conv_stb
);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_NMASK = AW'(1), A_JMASK = AW'(2),
                            A_TIM  = AW'(3), A_STAT  = AW'(4), A_EOC   = AW'(5);

  logic           scan_q, trig_en_q, neoc_q, jeoc_q;
  logic [NCH-1:0] nmask_q, jmask_q, eoc_q;
  logic [2*TW-1:0] tim_q;
  logic [DW-1:0]  res_q [NCH];
  logic [DW-1:0]  conv_data;
  logic           ctrl_wr, stat_wr, eoc_wr, done, n_eoc, j_eoc, nbusy, jbusy;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign stat_wr = wr_en && (wr_addr == A_STAT);
  assign eoc_wr  = wr_en && (wr_addr == A_EOC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= 1'b0; trig_en_q <= 1'b0; nmask_q <= '0; jmask_q <= '0; tim_q <= '0;
    end else begin
      if (ctrl_wr) begin
        scan_q    <= wr_data[0];
        trig_en_q <= wr_data[3];
      end
      if (wr_en && wr_addr == A_NMASK) nmask_q <= wr_data[NCH-1:0];
      if (wr_en && wr_addr == A_JMASK) jmask_q <= wr_data[NCH-1:0];
      if (wr_en && wr_addr == A_TIM)   tim_q   <= wr_data[2*TW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neoc_q <= 1'b0; jeoc_q <= 1'b0;
    end else begin
      if (n_eoc)                      neoc_q <= 1'b1;
      else if (stat_wr && wr_data[2]) neoc_q <= 1'b0;
      if (j_eoc)                      jeoc_q <= 1'b1;
      else if (stat_wr && wr_data[3]) jeoc_q <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        eoc_q[c] <= 1'b0;
        res_q[c] <= '0;
      end else if (done && ch_sel == CHW'(c)) begin
        eoc_q[c] <= 1'b1;
        res_q[c] <= conv_data;
      end else if (eoc_wr && wr_data[c]) begin
        eoc_q[c] <= 1'b0;
      end
    end
  end

  adc_seq_fsm #(.NCH(NCH), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scan_i(scan_q), .nmask_i(nmask_q), .jmask_i(jmask_q),
    .samp_i(tim_q[TW-1:0]), .conv_i(tim_q[2*TW-1:TW]),
    .nstart_i(ctrl_wr && wr_data[1]), .jstart_i(ctrl_wr && wr_data[2]),
    .abort_ch_i(ctrl_wr && wr_data[4]), .abort_chain_i(ctrl_wr && wr_data[5]),
    .trig_en_i(trig_en_q), .trig_req_i(trig_req), .trig_ch_i(trig_ch),
    .ch_o(ch_sel), .sample_o(sample_stb), .conv_o(conv_stb), .done_o(done),
    .n_eoc_o(n_eoc), .j_eoc_o(j_eoc), .nbusy_o(nbusy), .jbusy_o(jbusy)
  );

  adc_conv_stub #(.NCH(NCH), .DW(DW)) u_stub (
    .clk(clk), .rst_n(rst_n), .ain_i(ain), .ch_i(ch_sel),
    .sample_i(sample_stb), .data_o(conv_data)
  );

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = DW'({trig_en_q, 2'b00, scan_q});
      A_NMASK: rd_data = DW'(nmask_q);
      A_JMASK: rd_data = DW'(jmask_q);
      A_TIM:   rd_data = DW'(tim_q);
      A_STAT:  rd_data = DW'({jeoc_q, neoc_q, jbusy, nbusy});
      A_EOC:   rd_data = DW'(eoc_q);
      default: rd_data = rd_addr[AW-1] ? res_q[rd_addr[CHW-1:0]] : '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sample_stb,
  input logic           conv_stb,
  input logic [CHW-1:0] ch_sel,
  input logic [NCH-1:0] eocf,
  input logic           nbusy,
  input logic           neoc
);
  // R2: a convert phase is always entered from a sample phase
  p_conv_after_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_stb) |-> $past(sample_stb));

  // R2: channel select holds through the convert phase
  p_chsel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_stb && $past(conv_stb)) |-> $stable(ch_sel));

  // R4: an end-of-conversion flag only appears right after a convert phase
  p_eoc_from_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eocf & ~$past(eocf))) |-> $past(conv_stb));

  // R4: the flag that appears belongs to the channel just converted
  p_eoc_right_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eocf & ~$past(eocf))) |-> eocf[$past(ch_sel)]);

  // R5: when the normal chain empties its end-of-chain flag is set
  p_chain_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nbusy) |-> neoc);
endmodule

bind adc_chain_seq adc_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .conv_stb(conv_stb),
  .ch_sel(ch_sel), .eocf(eoc_q), .nbusy(nbusy), .neoc(neoc_q)
);

// File: tb/sim_adc_chain_seq.sv
`timescale 1ns/1ps
module sim_adc_chain_seq;
  logic        clk, rst_n, wr_en, trig_req, sample_stb, conv_stb;
  logic [3:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  logic [1:0]  trig_ch, ch_sel;
  logic [31:0] ain;

  int nchk = 0, nfail = 0;
  int se = 2, ce = 2;
  int lg_ch[64], lg_ns[64], lg_nc[64];
  int lc = 0;
  bit prev_s = 0;
  int ex_ch[16];
  bit ex_ok[16];
  int ex_n = 0;

  adc_chain_seq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .trig_req(trig_req),
    .trig_ch(trig_ch), .ain(ain), .ch_sel(ch_sel), .sample_stb(sample_stb),
    .conv_stb(conv_stb));

  initial clk = 0;
  always #2.5 clk = ~clk;

  // conversion log: a new entry opens at each start of a sample phase
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_stb && !prev_s && lc < 64) begin
        lg_ch[lc] = ch_sel; lg_ns[lc] = 0; lg_nc[lc] = 0; lc++;
      end
      if (lc > 0 && lc <= 64) begin
        if (sample_stb) lg_ns[lc-1]++;
        if (conv_stb)   lg_nc[lc-1]++;
      end
      prev_s = sample_stb;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 4'(a); #0.1; d = rd_data;
  endtask

  task automatic trig(input int c);
    trig_req = 1; trig_ch = 2'(c);
    @(posedge clk); @(negedge clk);
    trig_req = 0;
  endtask

  task automatic timing(input int s, input int c);
    wr(3, (c << 4) | s);
    se = (s < 2) ? 2 : s; ce = (c < 2) ? 2 : c;
  endtask

  task automatic ex(input int c, input bit ok);
    ex_ch[ex_n] = c; ex_ok[ex_n] = ok; ex_n++;
  endtask

  task automatic fresh();
    wr(4, 8'h0C); wr(5, 8'hFF); lc = 0; ex_n = 0;
  endtask

  task automatic wait_idle();
    int q = 0; int st;
    while (q < 3) begin
      @(negedge clk);
      rd(4, st);
      if (!sample_stb && !conv_stb && (st & 3) == 0) q++; else q = 0;
    end
  endtask

  task automatic chk_log(input string req);
    int bad = -1; int a = 0; int e = 0;
    for (int i = 0; i < ex_n && i < lc; i++) begin
      bit comp = (lg_ns[i] == se) && (lg_nc[i] == ce);
      if (bad < 0 && (lg_ch[i] != ex_ch[i] || comp != ex_ok[i])) begin
        bad = i; a = lg_ch[i] * 2 + int'(comp); e = ex_ch[i] * 2 + int'(ex_ok[i]);
      end
    end
    if (lc != ex_n) chk(0, req, lc, ex_n);
    else chk(bad < 0, req, a, e);
  endtask

  function automatic int count_done(input int c);
    int n = 0;
    for (int i = 0; i < lc; i++)
      if (lg_ch[i] == c && lg_ns[i] == se && lg_nc[i] == ce) n++;
    return n;
  endfunction

  initial begin
    int v, st;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    trig_req = 0; trig_ch = 0; ain = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!sample_stb && !conv_stb, "R1 strobes", {sample_stb, conv_stb}, 0);
    rd(4, v); chk(v == 0, "R1 status", v, 0);
    rd(5, v); chk(v == 0, "R1 eocf", v, 0);

    // R2 R3 R4 R5: sweep of timings and masks
    for (int s = 0; s < 5; s++)
      for (int c = 0; c < 5; c++)
        for (int m = 1; m < 16; m++) begin
          for (int k = 0; k < 4; k++) ain[k*8 +: 8] = 8'((s*40 + c*7 + k*53 + m*11) & 255);
          timing(s, c); wr(1, m); fresh();
          for (int k = 0; k < 4; k++) if (m[k]) ex(k, 1);
          wr(0, 8'h02);
          rd(4, st); chk((st & 1) == 1, "R5 busy while running", st, 1);
          wait_idle();
          chk_log("R2 R3 order and phase lengths");
          rd(5, v); chk(v == m, "R4 eoc flags", v, m);
          for (int k = 0; k < 4; k++)
            if (m[k]) begin
              rd(8 + k, v);
              chk(v == ain[k*8 +: 8], "R4 result", v, ain[k*8 +: 8]);
            end
          rd(4, st); chk(st == 4, "R5 one-shot end", st, 4);
        end
    fresh();
    rd(4, v); chk(v == 0, "R5 status w1c", v, 0);
    rd(5, v); chk(v == 0, "R4 eoc w1c", v, 0);

    timing(2, 3);
    for (int k = 0; k < 4; k++) ain[k*8 +: 8] = 8'(8'h21 + k * 8'h1F);

    // R7 restart request during the last channel
    wr(1, 4'b0111); fresh();
    wr(0, 8'h02);
    do @(negedge clk); while (!(sample_stb && ch_sel == 2));
    wr(0, 8'h02);
    wait_idle();
    for (int r = 0; r < 2; r++) begin ex(0, 1); ex(1, 1); ex(2, 1); end
    chk_log("R7 held restart order");
    rd(4, v); chk(v == 4, "R7 status", v, 4);

    // R8 injected over normal
    wr(1, 4'b1111); wr(2, 4'b0111); fresh();
    wr(0, 8'h02);
    do @(negedge clk); while (!(sample_stb && ch_sel == 1));
    wr(0, 8'h04);
    wait_idle();
    ex(0,1); ex(1,0); ex(0,1); ex(1,1); ex(2,1); ex(1,1); ex(2,1); ex(3,1);
    chk_log("R8 injected ordering");
    rd(4, v); chk(v == 12, "R8 both chain flags", v, 12);

    // R9 abandon the third injected channel
    fresh();
    wr(0, 8'h02);
    do @(negedge clk); while (!(sample_stb && ch_sel == 1));
    wr(0, 8'h04);
    do @(negedge clk); while (!(conv_stb && ch_sel == 2));
    wr(0, 8'h10);
    wait_idle();
    ex(0,1); ex(1,0); ex(0,1); ex(1,1); ex(2,0); ex(1,1); ex(2,1); ex(3,1);
    chk_log("R9 abandon keeps normal restore");
    rd(5, v); chk(v == 15, "R9 eoc all normal", v, 15);

    // R9 abandoned channel leaves its flag clear
    wr(1, 0); wr(2, 4'b0101); fresh();
    wr(0, 8'h04);
    do @(negedge clk); while (!(conv_stb && ch_sel == 0));
    wr(0, 8'h10);
    wait_idle();
    ex(0, 0); ex(2, 1);
    chk_log("R9 injected abandon");
    rd(5, v); chk(v == 4, "R9 abandoned flag clear", v, 4);
    rd(4, v); chk(v == 8, "R9 injected chain flag", v, 8);

    // R10 end chain, then a full chain
    wr(1, 4'b1111); fresh();
    wr(0, 8'h02);
    do @(negedge clk); while (!(conv_stb && ch_sel == 1));
    wr(0, 8'h20);
    wait_idle();
    ex(0, 1); ex(1, 0);
    chk_log("R10 end chain");
    rd(5, v); chk(v == 1, "R10 eoc", v, 1);
    rd(4, v); chk(v == 4, "R10 chain flag", v, 4);
    fresh();
    wr(0, 8'h02);
    wait_idle();
    ex(0,1); ex(1,1); ex(2,1); ex(3,1);
    chk_log("R10 end chain acts once");

    // R6 scan mode
    wr(1, 4'b0011); fresh();
    wr(0, 8'h03);
    while (lc < 5) @(negedge clk);
    rd(4, v); chk((v & 1) == 1, "R6 busy during scan", v, 1);
    wr(0, 8'h21);
    wait_idle();
    ex_n = 0; ex(0,1); ex(1,1); ex(0,1); ex(1,1);
    v = 1;
    for (int i = 0; i < 4; i++)
      if (lg_ch[i] != ex_ch[i] || lg_ns[i] != se || lg_nc[i] != ce) v = 0;
    chk(v == 1, "R6 scan repeats in order", v, 1);
    rd(4, v); chk(v == 4, "R6 stopped with flag", v, 4);
    wr(0, 8'h00);

    // R11 trigger preempts a sampling normal channel
    wr(1, 4'b1100); wr(0, 8'h08); fresh();
    wr(0, 8'h0A);
    do @(negedge clk); while (!(sample_stb && ch_sel == 2));
    trig(1);
    wait_idle();
    ex(2,0); ex(1,1); ex(2,1); ex(3,1);
    chk_log("R11 trigger first");

    // R13 trigger during convert phase, channel restored
    wr(1, 4'b1111); fresh();
    wr(0, 8'h0A);
    do @(negedge clk); while (!(conv_stb && ch_sel == 1));
    trig(3);
    wait_idle();
    ex(0,1); ex(1,0); ex(3,1); ex(1,1); ex(2,1); ex(3,1);
    chk_log("R13 restore after convert preempt");
    rd(9, v); chk(v == ain[15:8], "R13 result kept", v, ain[15:8]);
    rd(5, v); chk(v == 15, "R13 eoc", v, 15);

    // R11 trigger at every cycle offset of a chain
    timing(2, 2); wr(1, 4'b0011);
    for (int k = 0; k < 24; k++) begin
      fresh();
      wr(0, 8'h0A);
      repeat (k) @(negedge clk);
      trig(3);
      wait_idle();
      v = count_done(3) * 100 + count_done(1) * 10 + count_done(0);
      chk(v == 111, "R11 trigger not lost", v, 111);
      rd(5, st); chk(st == 11, "R11 eoc", st, 11);
    end

    // R12 idle aborts and disabled trigger
    fresh();
    wr(0, 8'h18); wr(0, 8'h28);
    rd(4, v); chk(v == 0, "R12 idle abort status", v, 0);
    rd(5, v); chk(v == 0, "R12 idle abort eoc", v, 0);
    trig(2);
    wait_idle();
    ex(2, 1);
    chk_log("R12 trigger after idle abort");
    wr(0, 8'h00); fresh();
    trig(1);
    wait_idle();
    chk(lc == 0, "R12 disabled trigger ignored", lc, 0);
    rd(5, v); chk(v == 0, "R12 no flag", v, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule